// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Port

This block turns a stream of stereo sample pairs (two 24-bit two's-complement words) into a single-wire serial audio stream. It sends the most significant bit first and launches each bit on the falling edge of a bit clock. A two-bit role input chooses between two ways of running. In the three master roles the port divides its master clock down to a bit clock at 64 times the frame rate and drives that bit clock and the frame (left/right) clock out. In the slave role the port follows a bit clock and a frame clock from outside, at 48 or 32 bit periods per frame.

A format input selects one of two framings. In left-justified framing the MSB goes out in the first bit slot of a half-frame, and the left word is sent while the frame clock is high. In I2S-style framing the MSB is one slot late, and the left word is sent while the frame clock is low. The role and format pins are sampled only while reset is held, so a stream cannot be broken by a change at run time. The upstream logic offers sample pairs through a valid/ready handshake. The port holds one pending pair and moves it into the output frame at the start of each left half.

Top module: `aud_ser_tx`

## Requirements
- R1: The role input decodes as follows. 00 is master with the master clock at 256 times the frame rate. 10 is master at 512 times. 11 is master at 128 times. 01 is slave. In each master role, `bclk_o` rises once every ratio/64 master-clock cycles, which gives 2, 4 or 8 cycles.
- R2: In master roles, `lrck_o` holds each level for exactly 32 bit periods and changes only on a falling edge of `bclk_o`.
- R3: Serial data changes only when the bit clock falls. Each word goes out MSB first, in two's complement, and is stable at the next rising edge.
- R4: With format 0 (left-justified), the frame clock is high for the left word. Bit 23 goes out in slot 0 of each half, down to bit 0 in slot 23. Slots 24 and later carry 0.
- R5: With format 1 (I2S-style), the frame clock is low for the left word. Slot 0 carries 0, and bits 23 down to 0 go out in slots 1 to 24. Later slots carry 0, and any bit that falls beyond the last slot of its half is dropped.
- R6: In slave role the port counts slots from each change of `ext_lrck` and launches on each falling edge of `ext_bclk`. It works with 24 or 16 slots per half. `bclk_o` and `lrck_o` stay low throughout.
- R7: The role and format pins are captured only while `rst_n` is low. Changing them after reset has no effect on the running stream.
- R8: `sdata_o` is low while reset is held and at all times while `out_en` is low. `bclk_o` and `lrck_o` are low during reset.
- R9: A pair is taken when `smp_valid` and `smp_ready` are both high at a clock edge. `smp_ready` is high after reset and drops on the edge that takes a pair. The pending pair is moved into the frame at the start of each left half, so frame n after reset carries the n-th accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; role and format are captured while low |
| role_sel | input | 2 | Port role and master-clock ratio (R1 encoding) |
| fmt_sel | input | 1 | 0 left-justified, 1 I2S-style framing |
| out_en | input | 1 | Output enable for serial data |
| ext_bclk | input | 1 | External bit clock, used in slave role |
| ext_lrck | input | 1 | External frame clock, used in slave role |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | The port can take a sample pair |
| smp_left | input | 24 | Left-channel sample |
| smp_right | input | 24 | Right-channel sample |
| bclk_o | output | 1 | Generated bit clock (master roles) |
| lrck_o | output | 1 | Generated frame clock (master roles) |
| sdata_o | output | 1 | Serial audio data |

## Verification
In master roles, `sdata_o` and `lrck_o` change on the same master-clock edge on which `bclk_o` falls, and `bclk_o` rises ratio/64 cycles after the previous rise. The bench therefore samples data and frame clock at the falling master-clock edge that follows each observed rise of `bclk_o`, and it counts the cycles between rises. In slave role, a launch lands three master-clock edges after the external bit clock falls: two synchronizer stages plus an edge register. The bench holds each external bit-clock phase for six cycles and samples just before it drives the rising edge. A pair accepted during frame n-1 is expected in frame n, so each decoded frame is compared with the accepted pair of the same index.

// File: rtl/aud_ser_pkg.sv
// Shared types for the serial audio transmit port.
// Assumes the role and format codes are fixed by the pin decode of R1/R4/R5.
package aud_ser_pkg;

    typedef enum logic [1:0] {
        ROLE_M256  = 2'b00,
        ROLE_SLAVE = 2'b01,
        ROLE_M512  = 2'b10,
        ROLE_M128  = 2'b11
    } port_role_e;

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } frame_fmt_e;

    // Master-clock cycles per frame for a role; 0 when the port is a slave.
    function automatic int role_ratio(port_role_e r);
        case (r)
            ROLE_M256: return 256;
            ROLE_M512: return 512;
            ROLE_M128: return 128;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/aud_ser_mclk_div.sv
// Master-role clock generator.
// Divides the master clock into a 50% bit clock (2*HALF_SLOTS bits per frame)
// and a 50% frame clock, and reports which slot is launched at each falling
// bit-clock edge. Assumes HALF_SLOTS is a power of two and role is held stable.
module aud_ser_mclk_div
    import aud_ser_pkg::*;
#(
    parameter int HALF_SLOTS = 32,
    parameter int MAX_RATIO  = 512,
    localparam int POS_W     = $clog2(HALF_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  port_role_e       role,
    input  frame_fmt_e       fmt,
    output logic             launch,
    output logic             half_right,
    output logic [POS_W-1:0] pos,
    output logic             bclk,
    output logic             lrck
);
    localparam int DIV_MAX = MAX_RATIO / (2 * HALF_SLOTS);
    localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

    logic [CNT_W-1:0] cnt_q, cnt_nxt, div_last;
    logic [CNT_W:0]   half_pt;
    logic [POS_W:0]   slot_q, slot_nxt;

    // Terminal count and high-phase threshold for the selected ratio.
    always_comb begin
        div_last = CNT_W'(role_ratio(role) / (2 * HALF_SLOTS) - 1);
        half_pt  = ({1'b0, div_last} + 1'b1) >> 1;
        cnt_nxt  = (cnt_q == div_last) ? '0 : cnt_q + 1'b1;
        launch   = enable && (cnt_q == div_last);
        slot_nxt = slot_q + 1'b1;
        half_right = slot_nxt[POS_W];
        pos        = slot_nxt[POS_W-1:0];
    end

    // Divider counter and registered bit clock (low then high within a bit).
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            bclk  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            bclk  <= ({1'b0, cnt_nxt} >= half_pt);
        end
    end

    // Slot counter and frame clock, both advanced on the falling bit edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            slot_q <= '1;
            lrck   <= 1'b0;
        end else if (launch) begin
            slot_q <= slot_nxt;
            lrck   <= (fmt == FMT_I2S) ? slot_nxt[POS_W] : ~slot_nxt[POS_W];
        end
    end

    // R2: frame clock only moves together with a falling bit clock.
    assert_lrck_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck) |-> $fell(bclk));

    // R3: every launch is a falling edge of the generated bit clock.
    assert_launch_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!bclk && $past(bclk)));

endmodule

// File: rtl/aud_ser_slave_trk.sv
// Slave-role slot tracker.
// Synchronizes the external bit and frame clocks into the master-clock domain,
// finds falling bit-clock edges, and restarts the slot count on each frame-clock
// change. Assumes the master clock is well above 2x the external bit clock and
// that both external clocks see the same synchronizer delay.
module aud_ser_slave_trk
    import aud_ser_pkg::*;
#(
    parameter int HALF_SLOTS  = 32,
    parameter int SYNC_STAGES = 2,
    localparam int POS_W      = $clog2(HALF_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  frame_fmt_e       fmt,
    input  logic             ext_bclk,
    input  logic             ext_lrck,
    output logic             launch,
    output logic             half_right,
    output logic [POS_W-1:0] pos
);
    logic [SYNC_STAGES-1:0] b_sync, l_sync;
    logic                   b_prev, l_last, right_q;
    logic [POS_W-1:0]       pos_q;
    logic                   b_now, l_now, lr_edge;

    // Synchronizer chains for both external clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_sync <= '0;
            l_sync <= '0;
            b_prev <= 1'b0;
        end else begin
            b_sync <= {b_sync[SYNC_STAGES-2:0], ext_bclk};
            l_sync <= {l_sync[SYNC_STAGES-2:0], ext_lrck};
            b_prev <= b_sync[SYNC_STAGES-1];
        end
    end

    // Falling-edge strobe and next slot position.
    always_comb begin
        b_now   = b_sync[SYNC_STAGES-1];
        l_now   = l_sync[SYNC_STAGES-1];
        launch  = enable && b_prev && !b_now;
        lr_edge = (l_now != l_last);
        if (lr_edge) begin
            pos        = '0;
            half_right = (fmt == FMT_I2S) ? l_now : ~l_now;
        end else begin
            pos        = (pos_q == POS_W'(HALF_SLOTS - 1)) ? pos_q : pos_q + 1'b1;
            half_right = right_q;
        end
    end

    // Slot state updated at each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '1;
            right_q <= 1'b1;
            l_last  <= 1'b0;
        end else if (launch) begin
            pos_q   <= pos;
            right_q <= half_right;
            l_last  <= l_now;
        end
    end

    // R6: a frame-clock change always restarts counting at slot 0.
    assert_slot_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && lr_edge) |=> (pos_q == '0));

endmodule

// File: rtl/aud_ser_shift.sv
// Sample holding and bit selection.
// Holds one pending pair from the handshake, moves it into the frame at the
// start of each left half, and drives the bit for each launched slot.
// Assumes launch/half_right/pos describe the slot that begins at this edge.
module aud_ser_shift
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int HALF_SLOTS = 32,
    localparam int POS_W     = $clog2(HALF_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                out_en,
    input  frame_fmt_e          fmt,
    input  logic                launch,
    input  logic                half_right,
    input  logic [POS_W-1:0]    pos,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                sdata
);
    logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r, word;
    logic                pend_full, frame_start, accept, bit_val;
    int                  rel;

    // Handshake and frame-start decode.
    always_comb begin
        smp_ready   = ~pend_full;
        accept      = smp_valid && smp_ready;
        frame_start = launch && !half_right && (pos == '0);
    end

    // Pending pair register and current frame words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_l    <= '0;
            pend_r    <= '0;
            cur_l     <= '0;
            cur_r     <= '0;
        end else begin
            if (frame_start) begin
                cur_l <= pend_full ? pend_l : '0;
                cur_r <= pend_full ? pend_r : '0;
            end
            if (accept) begin
                pend_l    <= smp_left;
                pend_r    <= smp_right;
                pend_full <= 1'b1;
            end else if (frame_start) begin
                pend_full <= 1'b0;
            end
        end
    end

    // Bit for the launched slot, bypassing the frame load on the first slot.
    always_comb begin
        if (half_right)       word = cur_r;
        else if (frame_start) word = pend_full ? pend_l : '0;
        else                  word = cur_l;
        rel = int'(pos) - ((fmt == FMT_I2S) ? 1 : 0);
        if (rel >= 0 && rel < SAMPLE_W) bit_val = word[SAMPLE_W-1-rel];
        else                            bit_val = 1'b0;
    end

    // Serial data register, launched on the falling bit edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !out_en) sdata <= 1'b0;
        else if (launch)       sdata <= bit_val;
    end

    // R8: data is quiet in the cycle after output enable was low.
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(out_en) |-> !sdata);

    // R9: taking a pair closes the handshake on the following cycle.
    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    // R4: slots past the longest sample window always carry zero.
    assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && (int'(pos) > SAMPLE_W)) |=> !sdata);

endmodule

// File: rtl/aud_ser_tx.sv
// Stereo serial audio transmit port (top).
// Captures role and format while reset is low, runs either the master clock
// generator or the slave tracker, and feeds the chosen slot stream to the
// serializer. Assumes one clock domain (mclk) and synchronous active-low reset.
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int HALF_SLOTS  = 32,
    parameter int MAX_RATIO   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic [1:0]          role_sel,
    input  logic                fmt_sel,
    input  logic                out_en,
    input  logic                ext_bclk,
    input  logic                ext_lrck,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                bclk_o,
    output logic                lrck_o,
    output logic                sdata_o
);
    localparam int POS_W = $clog2(HALF_SLOTS);

    port_role_e       role_q;
    frame_fmt_e       fmt_q;
    logic             is_master;
    logic             m_launch, m_right, m_bclk, m_lrck;
    logic [POS_W-1:0] m_pos;
    logic             s_launch, s_right;
    logic [POS_W-1:0] s_pos;
    logic             launch, half_right;
    logic [POS_W-1:0] pos;

    // Role and format are sampled only while reset is held.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            role_q <= port_role_e'(role_sel);
            fmt_q  <= frame_fmt_e'(fmt_sel);
        end
    end

    assign is_master = (role_q != ROLE_SLAVE);

    aud_ser_mclk_div #(
        .HALF_SLOTS (HALF_SLOTS),
        .MAX_RATIO  (MAX_RATIO)
    ) u_div (
        .clk        (mclk),
        .rst_n      (rst_n),
        .enable     (is_master),
        .role       (role_q),
        .fmt        (fmt_q),
        .launch     (m_launch),
        .half_right (m_right),
        .pos        (m_pos),
        .bclk       (m_bclk),
        .lrck       (m_lrck)
    );

    aud_ser_slave_trk #(
        .HALF_SLOTS  (HALF_SLOTS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trk (
        .clk        (mclk),
        .rst_n      (rst_n),
        .enable     (!is_master),
        .fmt        (fmt_q),
        .ext_bclk   (ext_bclk),
        .ext_lrck   (ext_lrck),
        .launch     (s_launch),
        .half_right (s_right),
        .pos        (s_pos)
    );

    // Slot stream and clock outputs from whichever side owns the role.
    always_comb begin
        launch     = is_master ? m_launch : s_launch;
        half_right = is_master ? m_right  : s_right;
        pos        = is_master ? m_pos    : s_pos;
        bclk_o     = is_master && m_bclk;
        lrck_o     = is_master && m_lrck;
    end

    aud_ser_shift #(
        .SAMPLE_W   (SAMPLE_W),
        .HALF_SLOTS (HALF_SLOTS)
    ) u_shift (
        .clk        (mclk),
        .rst_n      (rst_n),
        .out_en     (out_en),
        .fmt        (fmt_q),
        .launch     (launch),
        .half_right (half_right),
        .pos        (pos),
        .smp_valid  (smp_valid),
        .smp_ready  (smp_ready),
        .smp_left   (smp_left),
        .smp_right  (smp_right),
        .sdata      (sdata_o)
    );

    // R7: captured configuration never moves outside reset.
    assert_cfg_hold_R7: assert property (@(posedge mclk) disable iff (!rst_n)
        rst_n |=> ($stable(role_q) && $stable(fmt_q)));

    // R6: no clocks are driven out in slave role.
    assert_slave_quiet_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        (role_q == ROLE_SLAVE) |-> (!bclk_o && !lrck_o));

endmodule

// File: tb/sim_aud_ser_tx.sv
module sim_aud_ser_tx;
    localparam int W = 24;

    logic         mclk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   role_sel = 2'b00;
    logic         fmt_sel = 1'b0;
    logic         out_en = 1'b1;
    logic         ext_bclk = 1'b0;
    logic         ext_lrck = 1'b0;
    logic         smp_valid = 1'b0;
    logic         smp_ready;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic         bclk_o, lrck_o, sdata_o;

    always #4 mclk = ~mclk;   // 125 MHz

    aud_ser_tx u0 (
        .mclk(mclk), .rst_n(rst_n), .role_sel(role_sel), .fmt_sel(fmt_sel),
        .out_en(out_en), .ext_bclk(ext_bclk), .ext_lrck(ext_lrck),
        .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right),
        .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
    );

    int           checks = 0;
    int           errors = 0;
    int           n_push = 0;
    logic [W-1:0] q_l [0:63];
    logic [W-1:0] q_r [0:63];
    logic         b_last = 1'b0;
    bit           done = 0;

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected bit of a slot, from R4 (left-justified) and R5 (I2S-style).
    function automatic logic exp_bit(logic [W-1:0] s, bit i2s, int p);
        int rel = p - (i2s ? 1 : 0);
        if (rel < 0 || rel >= W) return 1'b0;
        return s[W-1-rel];
    endfunction

    // Feeder: records every accepted pair in order, then offers a random one.
    initial begin
        forever begin
            @(negedge mclk);
            if (rst_n && smp_valid && smp_ready) begin
                if (n_push < 64) begin
                    q_l[n_push] = smp_left;
                    q_r[n_push] = smp_right;
                end
                n_push++;
                @(posedge mclk);
                #1;
                smp_left  = W'($urandom);
                smp_right = W'($urandom);
            end
        end
    end

    task automatic apply_reset(logic [1:0] role, bit i2s, bit oe, logic [W-1:0] l0, logic [W-1:0] r0);
        @(posedge mclk); #1;
        rst_n = 1'b0;
        role_sel = role; fmt_sel = i2s; out_en = oe;
        smp_valid = 1'b1; smp_left = l0; smp_right = r0;
        n_push = 0; b_last = 1'b0;
        repeat (4) @(negedge mclk);
        // R8: outputs quiet in reset; R9: handshake open after reset
        check(!sdata_o && !bclk_o && !lrck_o, "R8 reset outputs",
              {61'd0, sdata_o, bclk_o, lrck_o}, 64'd0);
        check(smp_ready, "R9 ready in reset", {63'd0, smp_ready}, 64'd1);
        @(posedge mclk); #1;
        rst_n = 1'b1;
    endtask

    task automatic next_rise(output int gap);
        bit hit;
        gap = 0;
        do begin
            @(negedge mclk);
            gap++;
            hit = bclk_o && !b_last;
            b_last = bclk_o;
        end while (!hit && gap < 5000);
    endtask

    task automatic run_master(logic [1:0] role, bit i2s, int dv, int frames, bit oe, bit scramble,
                              logic [W-1:0] l0, logic [W-1:0] r0);
        int gap;
        logic [63:0] got_d, exp_d, got_lr, exp_lr;
        string ftag;
        ftag = i2s ? "R5" : "R4";
        apply_reset(role, i2s, oe, l0, r0);
        if (scramble) begin
            role_sel = 2'b01;
            fmt_sel  = ~i2s;
        end
        next_rise(gap);   // idle rise before slot 0
        for (int f = 0; f < frames; f++) begin
            int bad_gap = 0;
            for (int s = 0; s < 64; s++) begin
                next_rise(gap);
                if (gap != dv) bad_gap++;
                got_d[63-s]  = sdata_o;
                got_lr[63-s] = lrck_o;
                exp_d[63-s]  = !oe ? 1'b0 :
                               (s < 32 ? exp_bit(q_l[f], i2s, s) : exp_bit(q_r[f], i2s, s - 32));
                exp_lr[63-s] = (s < 32) ? !i2s : i2s;
            end
            check(bad_gap == 0, "R1 bit clock period", 64'(bad_gap), 64'd0);
            check(got_lr == exp_lr, "R2 frame clock", got_lr, exp_lr);
            if (!oe)
                check(got_d == exp_d, "R8 data off", got_d, exp_d);
            else if (scramble)
                check(got_d == exp_d, "R7 pins ignored after reset", got_d, exp_d);
            else
                check(got_d == exp_d, {"R3/", ftag, "/R9 master frame"}, got_d, exp_d);
        end
    endtask

    task automatic slave_half(bit lvl, int slots, output logic [31:0] bits, output int bad_clk);
        bits = '0;
        bad_clk = 0;
        for (int p = 0; p < slots; p++) begin
            @(negedge mclk);
            ext_bclk = 1'b0;
            if (p == 0) ext_lrck = lvl;
            repeat (6) @(negedge mclk);
            bits[31-p] = sdata_o;
            if (bclk_o || lrck_o) bad_clk++;
            ext_bclk = 1'b1;
            repeat (5) @(negedge mclk);
        end
    endtask

    task automatic run_slave(bit i2s, int slots, int frames, logic [W-1:0] l0, logic [W-1:0] r0);
        logic [31:0] gl, gr, el, er;
        int bc, bc2;
        string ftag;
        ftag = i2s ? "R5" : "R4";
        ext_bclk = 1'b1;
        ext_lrck = i2s;   // right-half level
        apply_reset(2'b01, i2s, 1'b1, l0, r0);
        repeat (10) @(negedge mclk);
        slave_half(i2s, slots, gl, bc);   // lead-in right half
        for (int f = 0; f < frames; f++) begin
            slave_half(!i2s, slots, gl, bc);
            slave_half(i2s, slots, gr, bc2);
            el = '0; er = '0;
            for (int p = 0; p < slots; p++) begin
                el[31-p] = exp_bit(q_l[f], i2s, p);
                er[31-p] = exp_bit(q_r[f], i2s, p);
            end
            check(bc + bc2 == 0, "R6 clocks idle in slave", 64'(bc + bc2), 64'd0);
            check({gl, gr} == {el, er}, {"R6/R3/", ftag, " slave frame"}, {gl, gr}, {el, er});
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        run_master(2'b00, 1'b0, 4, 3, 1'b1, 1'b0, 24'h800000, 24'h7FFFFF);
        run_master(2'b10, 1'b1, 8, 3, 1'b1, 1'b0, 24'hFFFFFF, 24'h000001);
        run_master(2'b11, 1'b0, 2, 3, 1'b1, 1'b0, 24'hA5A5A5, 24'h5A5A5A);
        run_master(2'b11, 1'b1, 2, 3, 1'b1, 1'b0, 24'h000001, 24'h800000);
        run_master(2'b00, 1'b1, 4, 2, 1'b0, 1'b0, 24'hFFFFFF, 24'hFFFFFF);
        run_master(2'b00, 1'b0, 4, 3, 1'b1, 1'b1, 24'h123456, 24'hFEDCBA);
        run_slave(1'b0, 24, 3, 24'h800001, 24'h7FFFFE);
        run_slave(1'b1, 16, 3, 24'hC00003, 24'h3FFFFC);
        run_slave(1'b1, 24, 2, 24'hFFFFFF, 24'h000001);
        run_slave(1'b0, 16, 2, 24'h0000FF, 24'hFF0000);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge mclk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule